// File: doc/BRIEF.md
# Instruction-Sequenced Static Mesh Switch

This block is the routing switch of one tile in a two-dimensional mesh of processing tiles. It joins five links: the four neighbour links (north, east, south, west) and the port of the tile's own processor. It makes no routing decisions of its own and never looks at the words it carries. A compiler-built schedule, held in a small instruction memory private to the switch, is stepped through by the switch's own program counter. Each instruction word says which input link supplies a word and which output links receive it.

Every link is buffered on both sides by a FIFO with valid/ready flow control. The processor writes operands into the switch through link 4 and reads operands back from it; on the processor side, these FIFOs appear as named registers. An instruction word carries several route slots that complete together. It is held, with the program counter frozen, until every source it names has a word and every destination it names has room. One slot can copy a word to several outputs in the same cycle. A word whose slots collide is reported on a sticky error output.

The schedule is loaded through a plain address/data write port while the switch is held idle by a low `run` input.

Top module: `static_route_switch`

## Requirements
- R1: After a synchronous active-low reset, the program counter is 0 and all ten FIFOs are empty, so every `link_out_valid` bit is 0, every `link_in_ready` bit is 1, and `conflict` is 0.
- R2: An instruction word is ROUTES slots of 8 bits plus a top bit. Slot k takes bits [8k+7:8k]. Its upper 3 bits are the source code: 0 north, 1 east, 2 south, 3 west, 4 processor, and 5 to 7 mean the slot is idle. Its lower 5 bits are a destination mask in which bit j selects output link j, using the same port numbering. The top bit (bit 8*ROUTES) is the loop bit.
- R3: A word completes only in a cycle in which every active slot's input FIFO holds a word and every selected output FIFO has space. Otherwise no FIFO is pushed or popped and the program counter holds.
- R4: A slot with several destination bits writes the same word into all of those output FIFOs in one cycle, and pops its source exactly once.
- R5: All active slots of one word move their words in the same cycle.
- R6: After a word completes, the program counter goes to 0 if the loop bit is set. Otherwise it goes to the next address, wrapping from IMEM_DEPTH-1 to 0.
- R7: If two active slots name the same source or share a destination bit, the word never completes. `conflict` then rises and stays at 1 until reset.
- R8: While `run` is 0, nothing moves and the program counter holds, and `prog_we` writes `prog_data` to address `prog_addr`. While `run` is 1, `prog_we` has no effect.
- R9: Each input FIFO accepts a word when valid and ready are both high, and holds FIFO_DEPTH words, deasserting ready when full. Each output link delivers its words in schedule order.
- R10: An active slot with an all-zero destination mask still pops its source word and discards it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | 1 lets the schedule execute; 0 holds the switch idle for loading |
| prog_we | input | 1 | Instruction memory write strobe (used only while run is 0) |
| prog_addr | input | $clog2(IMEM_DEPTH) | Instruction memory write address |
| prog_data | input | 8*ROUTES+1 | Instruction word to write |
| link_in_valid | input | 5 | Per-link input valid, bit j = link j |
| link_in_data | input | 5*DATA_W | Per-link input word, link j at bits [j*DATA_W +: DATA_W] |
| link_in_ready | output | 5 | Per-link input FIFO has space |
| link_out_valid | output | 5 | Per-link output FIFO holds a word |
| link_out_data | output | 5*DATA_W | Per-link output word, same packing as the input |
| link_out_ready | input | 5 | Per-link consumer takes the word |
| conflict | output | 1 | Sticky flag for a word whose slots collide |

## Verification
The embedded assertions watch the sequencing on every cycle. They check that the program counter freezes whenever no word completes or the switch is idle, that it steps by one or returns to 0 exactly as the loop bit says, that no FIFO is pushed when full or popped when empty, and that a raised conflict flag stays up and blocks all traffic. Only the bench scenarios can show what moves where. These scenarios cover multicast copies reaching each destination exactly once, parallel slots, dropped words, delivery order against a schedule model under random back-pressure, the exact count of words absorbed before a full output chain stalls, and program writes ignored during a run.

// File: rtl/sw_pkg.sv
// Shared constants and types for the static route switch.
// Assumes five links numbered north=0, east=1, south=2, west=3, processor=4.
package sw_pkg;
    localparam int NPORT  = 5;
    localparam int SRC_W  = 3;
    localparam int SLOT_W = SRC_W + NPORT;

    typedef enum logic [SRC_W-1:0] {
        PORT_N    = 3'd0,
        PORT_E    = 3'd1,
        PORT_S    = 3'd2,
        PORT_W    = 3'd3,
        PORT_PROC = 3'd4
    } port_e;

    // One route slot: source code in the upper bits, destination mask below.
    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [NPORT-1:0] dst;
    } route_slot_t;
endpackage

// File: rtl/sw_fifo.sv
// Synchronous FIFO used on every link, both into and out of the switch.
// Assumes DEPTH is a power of two and that the caller never pushes when
// full nor pops when empty.
module sw_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign rdata = store[rd_ptr];

    // Data storage: write the pushed word at the write pointer.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);  // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R3
endmodule

// File: rtl/sw_seq.sv
// Switch instruction memory and program counter.
// Writes are taken only while run is low; the counter advances when the
// crossbar reports a completed word, either to the next address or to 0.
module sw_seq #(
    parameter int DEPTH = 16,
    parameter int IW    = 17,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          prog_we,
    input  logic [AW-1:0] prog_addr,
    input  logic [IW-1:0] prog_data,
    input  logic          advance,
    output logic [IW-1:0] instr
);
    logic [IW-1:0] imem [DEPTH];
    logic [AW-1:0] pc;
    logic          loop_bit;

    assign instr    = imem[pc];
    assign loop_bit = instr[IW-1];

    // Program load port, active only while the switch is held idle.
    always_ff @(posedge clk) begin
        if (prog_we && !run) imem[prog_addr] <= prog_data;
    end

    // Program counter: step or loop on completion, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc <= '0;
        else if (advance) pc <= loop_bit ? '0 : pc + 1'b1;
    end

    AST_PC_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !advance |=> $stable(pc));              // R3
    AST_PC_STEP:  assert property (@(posedge clk) disable iff (!rst_n)
                                   (advance && !loop_bit) |=> pc == AW'($past(pc) + 1'b1));                // R6
    AST_PC_LOOP:  assert property (@(posedge clk) disable iff (!rst_n) (advance && loop_bit) |=> pc == '0);  // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !run |-> !advance);                  // R8
endmodule

// File: rtl/sw_xbar.sv
// Route decode and crossbar. Combines all slots of the current word,
// detects slot collisions, decides whether the word can complete and
// produces the FIFO pops, pushes and pushed data for that cycle.
// Assumes FIFO status inputs are registered (no combinational loop).
module sw_xbar
    import sw_pkg::*;
#(
    parameter int W      = 32,
    parameter int ROUTES = 2
) (
    input  logic                          run,
    input  route_slot_t [ROUTES-1:0]      slots,
    input  logic [NPORT-1:0]              src_empty,
    input  logic [NPORT-1:0][W-1:0]       src_data,
    input  logic [NPORT-1:0]              dst_full,
    output logic [NPORT-1:0]              pop,
    output logic [NPORT-1:0]              push,
    output logic [NPORT-1:0][W-1:0]       push_data,
    output logic                          fire,
    output logic                          word_conflict
);
    logic [NPORT-1:0] src_all;
    logic [NPORT-1:0] dst_all;
    logic             srcs_ready;

    // Gather sources and destinations, flag collisions, check readiness.
    always_comb begin
        src_all       = '0;
        dst_all       = '0;
        word_conflict = 1'b0;
        srcs_ready    = 1'b1;
        for (int s = 0; s < ROUTES; s++) begin
            if (slots[s].src < SRC_W'(NPORT)) begin
                if (src_all[slots[s].src] || |(dst_all & slots[s].dst)) word_conflict = 1'b1;
                src_all[slots[s].src] = 1'b1;
                dst_all               = dst_all | slots[s].dst;
                if (src_empty[slots[s].src]) srcs_ready = 1'b0;
            end
        end
        fire = run && srcs_ready && !word_conflict && !(|(dst_all & dst_full));
        pop  = fire ? src_all : '0;
        push = fire ? dst_all : '0;
    end

    // Crossbar: each output takes the word of the slot that selects it.
    always_comb begin
        for (int d = 0; d < NPORT; d++) begin
            push_data[d] = '0;
            for (int s = 0; s < ROUTES; s++) begin
                if (slots[s].src < SRC_W'(NPORT) && slots[s].dst[d])
                    push_data[d] = src_data[slots[s].src];
            end
        end
    end
endmodule

// File: rtl/static_route_switch.sv
// Top of the static route switch for one mesh tile. Five links, each with
// an input FIFO and an output FIFO; link 4 faces the local processor.
// The sequencer supplies one instruction word per cycle and the crossbar
// moves words when the whole word can complete.
module static_route_switch
    import sw_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int IMEM_DEPTH = 16,
    parameter int ROUTES     = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            run,
    input  logic                            prog_we,
    input  logic [$clog2(IMEM_DEPTH)-1:0]   prog_addr,
    input  logic [ROUTES*8:0]               prog_data,
    input  logic [4:0]                      link_in_valid,
    input  logic [5*DATA_W-1:0]             link_in_data,
    output logic [4:0]                      link_in_ready,
    output logic [4:0]                      link_out_valid,
    output logic [5*DATA_W-1:0]             link_out_data,
    input  logic [4:0]                      link_out_ready,
    output logic                            conflict
);
    localparam int AW = $clog2(IMEM_DEPTH);
    localparam int IW = ROUTES * SLOT_W + 1;

    logic [IW-1:0]                 instr;
    route_slot_t [ROUTES-1:0]      slots;
    logic [NPORT-1:0]              in_empty, in_full, in_pop;
    logic [NPORT-1:0][DATA_W-1:0]  in_rdata;
    logic [NPORT-1:0]              out_empty, out_full, out_push;
    logic [NPORT-1:0][DATA_W-1:0]  out_wdata, out_rdata;
    logic                          fire, word_conflict, conflict_q;

    assign slots = instr[IW-2:0];

    sw_seq #(.DEPTH(IMEM_DEPTH), .IW(IW), .AW(AW)) i_seq (
        .clk(clk), .rst_n(rst_n), .run(run),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .advance(fire), .instr(instr)
    );

    sw_xbar #(.W(DATA_W), .ROUTES(ROUTES)) i_xbar (
        .run(run), .slots(slots),
        .src_empty(in_empty), .src_data(in_rdata), .dst_full(out_full),
        .pop(in_pop), .push(out_push), .push_data(out_wdata),
        .fire(fire), .word_conflict(word_conflict)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_link
        sw_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_in_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(link_in_valid[g] && !in_full[g]),
            .wdata(link_in_data[g*DATA_W +: DATA_W]),
            .pop(in_pop[g]), .rdata(in_rdata[g]),
            .full(in_full[g]), .empty(in_empty[g])
        );
        sw_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_out_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(out_push[g]), .wdata(out_wdata[g]),
            .pop(link_out_ready[g] && !out_empty[g]), .rdata(out_rdata[g]),
            .full(out_full[g]), .empty(out_empty[g])
        );
        assign link_in_ready[g]                   = !in_full[g];
        assign link_out_valid[g]                  = !out_empty[g];
        assign link_out_data[g*DATA_W +: DATA_W]  = out_rdata[g];
    end

    // Sticky collision flag, set by a colliding word while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                    conflict_q <= 1'b0;
        else if (run && word_conflict) conflict_q <= 1'b1;
    end
    assign conflict = conflict_q;

    AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) conflict_q |=> conflict_q);   // R7
    AST_CONFLICT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) conflict_q |-> !fire);        // R7
    AST_RESET_CLEAN:     assert property (@(posedge clk) disable iff (!rst_n)
                                          $past(!rst_n) |-> (link_out_valid == '0 && !conflict_q));         // R1
endmodule

// File: tb/test_static_route_switch.sv
module test_static_route_switch;
    localparam int W = 32, FD = 4, DEPTH = 16, NP = 5, IW = 17, AW = 4;

    logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, prog_we = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [IW-1:0] prog_data = '0;
    logic [NP-1:0] in_valid = '0, in_ready, out_valid, out_ready = '0;
    logic [NP-1:0][W-1:0] in_data = '0, out_data;
    logic conflict;

    always #10 clk = ~clk;

    static_route_switch #(.DATA_W(W), .FIFO_DEPTH(FD), .IMEM_DEPTH(DEPTH), .ROUTES(2)) i_static_route_switch (
        .clk(clk), .rst_n(rst_n), .run(run), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .link_in_valid(in_valid), .link_in_data(in_data),
        .link_in_ready(in_ready), .link_out_valid(out_valid), .link_out_data(out_data),
        .link_out_ready(out_ready), .conflict(conflict)
    );

    int n_tests = 0, n_fail = 0, cyc = 0, scen = 0;
    logic [IW-1:0] prog [DEPTH];
    int need [NP], txi [NP], rxcnt [NP], ecnt [NP];
    bit acc [NP];
    logic [W-1:0] rxd [NP][256];
    logic [W-1:0] expd [NP][256];
    int in_prob = 0, out_prob = 0;
    bit feed_en = 1'b0;

    function automatic logic [W-1:0] word_of(int sc, int p, int i);
        return {8'(sc), 8'(p), 16'(i)};
    endfunction
    function automatic logic [7:0] slot(int src, logic [4:0] m);
        return {3'(src), m};
    endfunction
    function automatic logic [IW-1:0] iword(bit j, logic [7:0] s1, logic [7:0] s0);
        return {j, s1, s0};
    endfunction

    // Link drivers and consumers, all acting at the falling edge.
    always @(negedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (acc[p]) txi[p]++;
            if (feed_en && txi[p] < need[p] && ($urandom % 100) < in_prob) begin
                in_valid[p] = 1'b1;
                in_data[p]  = word_of(scen, p, txi[p]);
            end else begin
                in_valid[p] = 1'b0;
            end
            acc[p] = in_valid[p] && in_ready[p];
            out_ready[p] = ($urandom % 100) < out_prob;
            if (out_ready[p] && out_valid[p]) begin
                if (rxcnt[p] < 256) rxd[p][rxcnt[p]] = out_data[p];
                rxcnt[p]++;
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(bit ok, string tag, string what, longint act, longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic do_reset();
        step();
        rst_n = 1'b0; run = 1'b0; feed_en = 1'b0; prog_we = 1'b0;
        in_prob = 100; out_prob = 100;
        for (int p = 0; p < NP; p++) begin
            need[p] = 0; txi[p] = 0; rxcnt[p] = 0; ecnt[p] = 0; acc[p] = 1'b0;
        end
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic clear_prog();
        for (int a = 0; a < DEPTH; a++) prog[a] = iword(1'b0, slot(7, 0), slot(7, 0));
    endtask

    task automatic load_prog();
        run = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            step();
            prog_we = 1'b1; prog_addr = AW'(a); prog_data = prog[a];
        end
        step();
        prog_we = 1'b0;
    endtask

    // Schedule model: n completed words, unlimited supply on every source.
    task automatic model(int n);
        int pc = 0;
        int used [NP];
        for (int p = 0; p < NP; p++) begin used[p] = 0; ecnt[p] = 0; end
        for (int k = 0; k < n; k++) begin
            for (int s = 0; s < 2; s++) begin
                logic [7:0] sl;
                int src;
                sl  = prog[pc][8*s +: 8];
                src = int'(sl[7:5]);
                if (src < NP) begin
                    for (int d = 0; d < NP; d++)
                        if (sl[d]) begin expd[d][ecnt[d]] = word_of(scen, src, used[src]); ecnt[d]++; end
                    used[src]++;
                end
            end
            pc = prog[pc][IW-1] ? 0 : (pc + 1) % DEPTH;
        end
        for (int p = 0; p < NP; p++) need[p] = used[p];
    endtask

    task automatic compare(string tag);
        for (int p = 0; p < NP; p++) begin
            bit ok = (rxcnt[p] == ecnt[p]);
            longint a = rxcnt[p], e = ecnt[p];
            for (int i = 0; i < ecnt[p] && ok; i++)
                if (rxd[p][i] !== expd[p][i]) begin ok = 1'b0; a = rxd[p][i]; e = expd[p][i]; end
            chk(ok, tag, $sformatf("link %0d stream", p), a, e);
        end
    endtask

    task automatic run_sched(string tag, int n, int ip, int op);
        int t = 0;
        bit done;
        do_reset();
        load_prog();
        scen++;
        model(n);
        in_prob = ip; out_prob = op; feed_en = 1'b1; run = 1'b1;
        do begin
            step(); t++;
            done = 1'b1;
            for (int p = 0; p < NP; p++) if (txi[p] < need[p] || rxcnt[p] < ecnt[p]) done = 1'b0;
        end while (!done && t < 3000);
        repeat (10) step();
        compare(tag);
        feed_en = 1'b0; run = 1'b0;
    endtask

    task automatic rand_prog();
        int len = 2 + int'($urandom % 7);
        clear_prog();
        for (int a = 0; a < len; a++) begin
            logic [4:0] us = '0, ud = '0;
            logic [7:0] s [2];
            for (int k = 0; k < 2; k++) begin
                if ($urandom % 4 == 0) s[k] = slot(7, 0);
                else begin
                    int src;
                    logic [4:0] m;
                    do src = int'($urandom % 5); while (us[src]);
                    m = 5'($urandom) & ~ud;
                    us[src] = 1'b1; ud = ud | m;
                    s[k] = slot(src, m);
                end
            end
            prog[a] = iword(a == len - 1, s[1], s[0]);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1957));
        for (int p = 0; p < NP; p++) begin need[p] = 0; txi[p] = 0; rxcnt[p] = 0; ecnt[p] = 0; acc[p] = 1'b0; end
        clear_prog();

        // R1: reset state at the ports
        do_reset();
        chk(out_valid == 5'h00, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == 5'h1f, "R1", "in_ready after reset", in_ready, 5'h1f);
        chk(conflict == 1'b0, "R1", "conflict after reset", conflict, 0);

        // R4 multicast, R2 encoding: west (3) to south (bit2) and processor (bit4), looping
        clear_prog();
        prog[0] = iword(1'b1, slot(7, 0), slot(3, 5'b10100));
        run_sched("R4", 6, 100, 60);

        // R5 parallel slots: north to east in slot 1, west to south+proc in slot 0
        clear_prog();
        prog[0] = iword(1'b1, slot(0, 5'b00010), slot(3, 5'b10100));
        run_sched("R5", 5, 70, 70);

        // R10 dropped word: word 0 pops west with empty mask, word 1 sends west to east
        clear_prog();
        prog[0] = iword(1'b0, slot(7, 0), slot(3, 5'b00000));
        prog[1] = iword(1'b1, slot(7, 0), slot(3, 5'b00010));
        run_sched("R10", 6, 100, 100);

        // R6 wrap without loop bit: all addresses used, even to east, odd to south
        clear_prog();
        for (int a = 0; a < DEPTH; a++) prog[a] = iword(1'b0, slot(7, 0), slot(0, (a % 2 == 0) ? 5'b00010 : 5'b00100));
        run_sched("R6", 20, 90, 90);

        // R3 / R9: full destination stalls; exactly 2*FD words absorbed
        do_reset();
        clear_prog();
        prog[0] = iword(1'b1, slot(7, 0), slot(3, 5'b00010));
        load_prog();
        scen++;
        need[3] = 2 * FD + 3; in_prob = 100; out_prob = 0; feed_en = 1'b1; run = 1'b1;
        repeat (40) step();
        chk(txi[3] == 2 * FD, "R3", "words absorbed before stall", txi[3], 2 * FD);
        chk(in_ready[3] == 1'b0, "R9", "west ready when full", in_ready[3], 0);
        chk(rxcnt[1] == 0, "R3", "east delivered while blocked", rxcnt[1], 0);
        for (int i = 0; i < need[3]; i++) expd[1][i] = word_of(scen, 3, i);
        for (int p = 0; p < NP; p++) ecnt[p] = 0;
        ecnt[1] = need[3];
        out_prob = 100;
        repeat (80) step();
        compare("R9");

        // R3 empty source stall, then R6 ordering through two words
        do_reset();
        clear_prog();
        prog[0] = iword(1'b0, slot(7, 0), slot(0, 5'b00010));
        prog[1] = iword(1'b1, slot(7, 0), slot(3, 5'b00010));
        load_prog();
        scen++;
        need[3] = 3; feed_en = 1'b1; run = 1'b1;
        repeat (40) step();
        chk(rxcnt[1] == 0, "R3", "east output with north empty", rxcnt[1], 0);
        chk(txi[3] == 3, "R3", "west words buffered", txi[3], 3);
        need[0] = 1;
        repeat (40) step();
        chk(rxcnt[1] == 2, "R6", "east count after north word", rxcnt[1], 2);
        chk(rxd[1][0] == word_of(scen, 0, 0), "R6", "east first word", rxd[1][0], word_of(scen, 0, 0));
        chk(rxd[1][1] == word_of(scen, 3, 0), "R6", "east second word", rxd[1][1], word_of(scen, 3, 0));

        // R8: nothing moves while run is low
        do_reset();
        clear_prog();
        prog[0] = iword(1'b1, slot(7, 0), slot(3, 5'b00010));
        load_prog();
        scen++;
        need[3] = FD; feed_en = 1'b1;
        repeat (30) step();
        chk(rxcnt[1] == 0, "R8", "east output while idle", rxcnt[1], 0);
        chk(txi[3] == FD, "R8", "west words held while idle", txi[3], FD);
        run = 1'b1;
        repeat (30) step();
        chk(rxcnt[1] == FD, "R8", "east output after run", rxcnt[1], FD);

        // R8: program write while running is ignored
        do_reset();
        load_prog();
        scen++;
        run = 1'b1;
        step();
        prog_we = 1'b1; prog_addr = '0; prog_data = iword(1'b1, slot(7, 0), slot(3, 5'b00100));
        step();
        prog_we = 1'b0;
        need[3] = 2; feed_en = 1'b1;
        repeat (30) step();
        chk(rxcnt[1] == 2, "R8", "east after ignored write", rxcnt[1], 2);
        chk(rxcnt[2] == 0, "R8", "south after ignored write", rxcnt[2], 0);

        // R7: colliding destinations flag and freeze
        do_reset();
        clear_prog();
        prog[0] = iword(1'b1, slot(0, 5'b00110), slot(3, 5'b00010));
        load_prog();
        scen++;
        need[0] = 1; need[3] = 1; feed_en = 1'b1; run = 1'b1;
        repeat (30) step();
        chk(conflict == 1'b1, "R7", "conflict raised", conflict, 1);
        chk(rxcnt[1] + rxcnt[2] == 0, "R7", "words moved by colliding word", rxcnt[1] + rxcnt[2], 0);
        run = 1'b0;
        repeat (20) step();
        chk(conflict == 1'b1, "R7", "conflict sticky", conflict, 1);
        do_reset();
        chk(conflict == 1'b0, "R1", "conflict cleared by reset", conflict, 0);

        // R2 / R9: random conflict-free schedules under random flow control
        for (int r = 0; r < 8; r++) begin
            rand_prog();
            run_sched("R2/R9", 10 + int'($urandom % 30), 30 + int'($urandom % 70), 30 + int'($urandom % 70));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule